// File: doc/BRIEF.md
# Wall-Following Maze Controller

This block steers a small two-antenna robot through a maze by keeping its right antenna in touch with a wall. Two contact inputs come in, one for each antenna, and each reads 1 while that antenna touches something. Three actuator commands go out: a forward step, a ten-degree left turn and a ten-degree right turn. Each clock cycle is one decision step.

The controller is a lookup table feeding a state register. The address is made of the current 2-bit state followed by the left and then the right antenna bit. The word read from that address holds the next state and the actuator commands that go with it. The table has 16 five-bit words and is filled with constants when the design is elaborated. No gate-level next-state equations exist outside it.

The actuator commands are captured in the same register as the state. They therefore always describe the state currently held and stay steady for the whole step.

Top module: `wf_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the controller is placed in the searching state (code 00) with `step_fwd`=1, `turn_left`=0 and `turn_right`=0 after that edge.
- R2: In the searching state (00) the controller stays in 00 when neither antenna touches, and moves to the backing-off state (01) when either antenna touches.
- R3: In the backing-off state (01) the controller stays in 01 while either antenna touches, and moves to the first wall state (10) when neither touches.
- R4: In the first wall state (10) the controller moves to the second wall state (11) when the right antenna touches and otherwise stays in 10. The left antenna has no effect in this state.
- R5: In the second wall state (11) a left touch moves the controller to 01, whatever the right antenna does. Otherwise a right touch keeps it in 11, and no touch moves it to 10.
- R6: The actions are a function of the state held: 00 gives forward only, 01 gives left turn only, 10 gives forward plus right turn, and 11 gives forward plus left turn. State and actions change together on the same edge, one cycle after the antenna values that caused the change are sampled.
- R7: `turn_left` and `turn_right` are never 1 in the same cycle.
- R8: Every one of the 16 state/antenna combinations yields a defined next state and defined actions. The outputs never carry X or Z once reset has been applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock; every rising edge is one decision |
| rst_n | input | 1 | Synchronous active-low reset |
| ant_l | input | 1 | Left antenna contact, 1 while touching |
| ant_r | input | 1 | Right antenna contact, 1 while touching |
| step_fwd | output | 1 | Take one step forward |
| turn_left | output | 1 | Rotate ten degrees counterclockwise |
| turn_right | output | 1 | Rotate ten degrees clockwise |
| state_q | output | 2 | Current state code: 00 searching, 01 backing off, 10 first wall, 11 second wall |

## Verification
Some properties hold on every cycle and are checked by assertions. These are the mutual exclusion of the two turn commands and the agreement between the held state and the actions it drives. They also cover the forbidden moves: the first wall state never jumps to backing off, and a touch in the searching state never leaves it searching. The full transition table, including the fact that the left antenna is ignored in the first wall state and the priority order in the second wall state, can only be shown by the bench's scripted antenna walks. Those walks visit all 16 addresses and apply a reset in the middle of a run.

// File: rtl/wf_pkg.sv
// Package: wf_pkg
// Shared widths, state codes, table word layout and the constant functions
// that fill the lookup table at elaboration time.
// Assumes: the address is {state, left, right}; the word is {next, tr, tl, fwd}.
package wf_pkg;

    localparam int ST_W    = 2;
    localparam int SENS_W  = 2;
    localparam int ACT_W   = 3;
    localparam int ADDR_W  = ST_W + SENS_W;
    localparam int WORD_W  = ST_W + ACT_W;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic [ST_W-1:0] {
        ST_SEARCH = 2'b00,
        ST_BACKOFF = 2'b01,
        ST_WALL_A = 2'b10,
        ST_WALL_B = 2'b11
    } wf_state_e;

    typedef struct packed {
        logic tr;
        logic tl;
        logic fwd;
    } wf_act_t;

    typedef struct packed {
        wf_state_e nxt;
        wf_act_t   act;
    } wf_word_t;

    // Actions that belong to a held state.
    function automatic wf_act_t act_for(input wf_state_e s);
        wf_act_t a;
        a = '0;
        case (s)
            ST_SEARCH:  a.fwd = 1'b1;
            ST_BACKOFF: a.tl  = 1'b1;
            ST_WALL_A:  begin a.fwd = 1'b1; a.tr = 1'b1; end
            default:    begin a.fwd = 1'b1; a.tl = 1'b1; end
        endcase
        return a;
    endfunction

    // Successor state used only to compute table contents.
    function automatic wf_state_e succ_for(input wf_state_e s, input logic l, input logic r);
        wf_state_e n;
        case (s)
            ST_SEARCH:  n = (l | r) ? ST_BACKOFF : ST_SEARCH;
            ST_BACKOFF: n = (l | r) ? ST_BACKOFF : ST_WALL_A;
            ST_WALL_A:  n = r ? ST_WALL_B : ST_WALL_A;
            default:    n = l ? ST_BACKOFF : (r ? ST_WALL_B : ST_WALL_A);
        endcase
        return n;
    endfunction

    // Table word stored at a given address: next state and its actions.
    function automatic wf_word_t word_for(input logic [ADDR_W-1:0] a);
        wf_word_t w;
        wf_state_e s;
        s     = wf_state_e'(a[ADDR_W-1:SENS_W]);
        w.nxt = succ_for(s, a[1], a[0]);
        w.act = act_for(w.nxt);
        return w;
    endfunction

endpackage

// File: rtl/wf_rom.sv
// Module: wf_rom
// Constant lookup table, one word per {state, left, right} address.
// Assumes: contents are fixed at elaboration; read is purely combinational.
module wf_rom
    import wf_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    localparam int NWORDS = 1 << AW;

    logic [DW-1:0] table_mem [NWORDS];

    // Fill each word from the constant contents function.
    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        localparam wf_word_t CONTENT = word_for(i[AW-1:0]);
        assign table_mem[i] = DW'(CONTENT);
    end

    // Read the addressed word.
    always_comb begin
        data = table_mem[addr];
    end

endmodule

// File: rtl/wf_state_reg.sv
// Module: wf_state_reg
// Holds the state and the actuator commands from the table word.
// Assumes: synchronous active-low reset; the word is {next, tr, tl, fwd}.
module wf_state_reg
    import wf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wf_word_t  d,
    output wf_state_e state,
    output wf_act_t   act
);

    // Capture the next state and its actions, or the reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SEARCH;
            act   <= act_for(ST_SEARCH);
        end else begin
            state <= d.nxt;
            act   <= d.act;
        end
    end

    // R1
    reset_value_chk: assert property (@(posedge clk) !rst_n |=>
        (state == ST_SEARCH && act.fwd && !act.tl && !act.tr));

    // R7
    turn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(act.tl && act.tr));

endmodule

// File: rtl/wf_ctrl.sv
// Module: wf_ctrl
// Wall-following controller: lookup table addressed by {state, L, R},
// feeding a register that holds the state and the actuator commands.
// Assumes: one decision per clock; antenna inputs already synchronous.
module wf_ctrl
    import wf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ant_l,
    input  logic            ant_r,
    output logic            step_fwd,
    output logic            turn_left,
    output logic            turn_right,
    output logic [ST_W-1:0] state_q
);

    logic [ADDR_W-1:0] rom_addr;
    logic [WORD_W-1:0] rom_data;
    wf_word_t          rom_word;
    wf_state_e         cur_state;
    wf_act_t           cur_act;

    // Form the table address from the held state and both antennas.
    always_comb begin
        rom_addr = {cur_state, ant_l, ant_r};
        rom_word = wf_word_t'(rom_data);
    end

    wf_rom #(.AW(ADDR_W), .DW(WORD_W)) i_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    wf_state_reg i_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rom_word),
        .state (cur_state),
        .act   (cur_act)
    );

    // Drive the ports from the held register.
    always_comb begin
        step_fwd   = cur_act.fwd;
        turn_left  = cur_act.tl;
        turn_right = cur_act.tr;
        state_q    = cur_state;
    end

    // R2
    search_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_SEARCH && (ant_l || ant_r)) |=> (state_q == ST_BACKOFF));

    // R4
    wall_a_no_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_WALL_A) |=> (state_q != ST_BACKOFF && state_q != ST_SEARCH));

    // R6
    backoff_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BACKOFF) |-> (turn_left && !turn_right && !step_fwd));

    // R6
    wall_a_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WALL_A) |-> (turn_right && step_fwd && !turn_left));

    // R8
    defined_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({rom_data, step_fwd, turn_left, turn_right, state_q}));

endmodule

// File: tb/test_wf_ctrl.sv
module test_wf_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ant_l = 1'b0;
    logic       ant_r = 1'b0;
    logic       step_fwd, turn_left, turn_right;
    logic [1:0] state_q;

    int checks = 0;
    int errors = 0;

    logic [1:0] model_st = 2'b00;
    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    wf_ctrl i_wf_ctrl (
        .clk(clk), .rst_n(rst_n), .ant_l(ant_l), .ant_r(ant_r),
        .step_fwd(step_fwd), .turn_left(turn_left), .turn_right(turn_right),
        .state_q(state_q)
    );

    // Actions {tr, tl, fwd} per state, taken from R6.
    function automatic logic [2:0] exp_act(input logic [1:0] s);
        case (s)
            2'b00:   return 3'b001;
            2'b01:   return 3'b010;
            2'b10:   return 3'b101;
            default: return 3'b011;
        endcase
    endfunction

    function automatic logic [1:0] exp_next(input logic [1:0] s, input logic l, input logic r);
        case (s)
            2'b00:   return (l || r) ? 2'b01 : 2'b00;  // R2
            2'b01:   return (l || r) ? 2'b01 : 2'b10;  // R3
            2'b10:   return r ? 2'b11 : 2'b10;         // R4
            default: return l ? 2'b01 : (r ? 2'b11 : 2'b10); // R5
        endcase
    endfunction

    function automatic string trans_tag(input logic [1:0] s);
        case (s)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Driver: apply one antenna pair and queue the expected result.
    task automatic step(input logic l, input logic r);
        logic [1:0] n;
        @(negedge clk);
        rst_n = 1'b1;
        ant_l = l;
        ant_r = r;
        n = exp_next(model_st, l, r);
        exp_q.push_back({n, exp_act(n)});
        tag_q.push_back(trans_tag(model_st));
        model_st = n;
    endtask

    // Driver: synchronous reset during a run with antennas touching. R1
    task automatic apply_reset(input logic l, input logic r);
        @(negedge clk);
        rst_n = 1'b0;
        ant_l = l;
        ant_r = r;
        exp_q.push_back({2'b00, 3'b001});
        tag_q.push_back("R1");
        model_st = 2'b00;
    endtask

    // Monitor: after each edge, compare outputs with the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n || exp_q.size() > 0) begin
                checks++;
                if (turn_left && turn_right) begin
                    errors++;
                    $display("FAIL R7 actual tl=%b tr=%b expected not both", turn_left, turn_right);
                end
                checks++;
                if ($isunknown({state_q, turn_right, turn_left, step_fwd})) begin
                    errors++;
                    $display("FAIL R8 actual=%b expected no X/Z",
                             {state_q, turn_right, turn_left, step_fwd});
                end
            end
            if (exp_q.size() > 0) begin
                logic [4:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {3'b000, state_q}, {3'b000, e[4:3]});
                // R6: actions follow the held state in the same cycle
                check("R6", {2'b00, turn_right, turn_left, step_fwd}, {2'b00, e[2:0]});
            end
        end
    end

    // Watchdog.
    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: initial reset
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", {state_q, turn_right, turn_left, step_fwd}, 5'b00_001);

        // Searching: idle, then each single touch. R2
        step(0, 0); step(0, 0); step(1, 0);
        apply_reset(1, 1);
        step(0, 1);
        apply_reset(0, 0);
        step(1, 1);
        // Backing off: all touch patterns. R3
        step(1, 0); step(0, 1); step(1, 1); step(0, 0);
        // First wall: left ignored, then right touch. R4
        step(0, 0); step(1, 0); step(1, 0); step(0, 1);
        // Second wall: right stays, neither returns. R5
        step(0, 1); step(0, 0);
        // First wall with both touching. R4
        step(1, 1);
        // Second wall: left-only and both both go back. R5
        step(1, 0);
        step(0, 0); step(0, 1); step(1, 1);
        // Longer corridor walk.
        step(0, 0); step(0, 1); step(0, 1); step(0, 0); step(1, 0);
        step(0, 1); step(0, 0); step(0, 0); step(1, 0);
        apply_reset(0, 1);
        step(0, 0); step(0, 0);
        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule